// File: doc/BRIEF.md
# Word and Doubleword Rotate Unit

This block rotates a 64-bit operand to the right and returns a 64-bit result in the same cycle. It serves the shift and rotate path of a 64-bit integer datapath. The decoder has already split the instruction word into an operation code, a 5-bit immediate count and a register value.

Two rotate widths are offered. The word rotate works on the low 32 bits of the operand only and sign-extends the rotated word to 64 bits. The doubleword rotate works on all 64 bits.

The count comes from one of three places:
- the immediate field;
- the immediate field with 32 added, so that doubleword counts from 32 to 63 can be reached without a register;
- the low bits of a register value.

Operation codes outside the defined set produce zero.

Top module: `rotate_unit`

## Requirements
- R1: With `op_sel_i` = 0 (word, immediate count), `result_o[31:0]` is `operand_i[31:0]` rotated right by `shamt_imm_i`. The value of `operand_i[63:32]` has no effect on the result.
- R2: For both word operations (`op_sel_i` 0 and 1), `result_o[63:32]` is filled with copies of `result_o[31]`.
- R3: With `op_sel_i` = 1 (word, register count), the count is `shamt_reg_i[4:0]`. Bits 63:5 of `shamt_reg_i` have no effect.
- R4: With `op_sel_i` = 2 (doubleword, immediate count), `result_o` is `operand_i` rotated right by `shamt_imm_i` (0 to 31).
- R5: With `op_sel_i` = 3 (doubleword, immediate plus 32), `result_o` is `operand_i` rotated right by `shamt_imm_i` + 32 (32 to 63).
- R6: With `op_sel_i` = 4 (doubleword, register count), the count is `shamt_reg_i[5:0]`. Bits 63:6 of `shamt_reg_i` have no effect.
- R7: A count of zero returns the operand unchanged:
  - for the doubleword operations, all 64 bits;
  - for the word operations, the low word sign-extended.
- R8: For `op_sel_i` values 5, 6 and 7, `result_o` is all zeros.
- R9: `result_o` follows its inputs combinationally. It holds no state and no clock edge lies between a change of input and the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 64 | Value to be rotated |
| shamt_imm_i | input | 5 | Immediate rotate count from the instruction field |
| shamt_reg_i | input | 64 | Register value whose low bits give the variable count |
| op_sel_i | input | 3 | Operation: 0 word-imm, 1 word-reg, 2 dword-imm, 3 dword-imm+32, 4 dword-reg, 5..7 reserved |
| result_o | output | 64 | Rotated, and for word operations sign-extended, result |

## Verification
The block has no state. A fault in the count selection or in one barrel stage therefore shows at `result_o` in the same cycle that the inputs that expose it are applied.

A stuck stage bit only shows when the matching count bit is set. A wrong choice of count bits only shows when the register carries set bits above the field. The stimulus therefore mixes:
- random counts;
- register values with dense upper bits;
- the zero, 31 and 63 boundaries.

A missing sign extension shows as soon as a word result has bit 31 set.

// File: rtl/rot_pkg.sv
package rot_pkg;

    localparam int unsigned XLEN   = 64;
    localparam int unsigned HLEN   = XLEN / 2;
    localparam int unsigned AMT_W  = $clog2(XLEN);
    localparam int unsigned IMM_W  = AMT_W - 1;

    typedef enum logic [2:0] {
        ROT_OP_WORD_IMM    = 3'd0,
        ROT_OP_WORD_REG    = 3'd1,
        ROT_OP_DWORD_IMM   = 3'd2,
        ROT_OP_DWORD_IMMHI = 3'd3,
        ROT_OP_DWORD_REG   = 3'd4
    } rot_op_e;

    typedef struct packed {
        logic             valid;
        logic             is_word;
        logic [AMT_W-1:0] amt;
    } rot_ctl_t;

endpackage

// File: rtl/rot_amt_sel.sv
module rot_amt_sel
    import rot_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [2:0]    op_i,
    input  logic [AW-2:0] imm_i,
    input  logic [W-1:0]  reg_i,
    output rot_ctl_t      ctl_o
);

    rot_ctl_t ctl_d;
    logic     unused_reg_hi;

    assign unused_reg_hi = ^reg_i[W-1:AW];

    always_comb begin
        ctl_d = '0;
        case (rot_op_e'(op_i))
            ROT_OP_WORD_IMM: begin
                ctl_d.valid   = 1'b1;
                ctl_d.is_word = 1'b1;
                ctl_d.amt     = {1'b0, imm_i};
            end
            ROT_OP_WORD_REG: begin
                ctl_d.valid   = 1'b1;
                ctl_d.is_word = 1'b1;
                ctl_d.amt     = {1'b0, reg_i[AW-2:0]};
            end
            ROT_OP_DWORD_IMM: begin
                ctl_d.valid   = 1'b1;
                ctl_d.amt     = {1'b0, imm_i};
            end
            ROT_OP_DWORD_IMMHI: begin
                ctl_d.valid   = 1'b1;
                ctl_d.amt     = {1'b1, imm_i};
            end
            ROT_OP_DWORD_REG: begin
                ctl_d.valid   = 1'b1;
                ctl_d.amt     = reg_i[AW-1:0];
            end
            default: ctl_d = '0;
        endcase
    end

    assign ctl_o = ctl_d;

endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
    parameter int unsigned W  = 64,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  din_i,
    input  logic [AW-1:0] amt_i,
    output logic [W-1:0]  dout_o
);

    logic [W-1:0] stage_d [AW+1];

    assign stage_d[0] = din_i;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int unsigned S = 1 << k;
        assign stage_d[k+1] = amt_i[k] ? {stage_d[k][S-1:0], stage_d[k][W-1:S]}
                                       : stage_d[k];
    end

    assign dout_o = stage_d[AW];

endmodule

// File: rtl/rot_result_fmt.sv
module rot_result_fmt
    import rot_pkg::*;
#(
    parameter int unsigned W = XLEN,
    parameter int unsigned H = W / 2
) (
    input  rot_ctl_t     ctl_i,
    input  logic [H-1:0] word_i,
    input  logic [W-1:0] dword_i,
    output logic [W-1:0] result_o
);

    logic [W-1:0] result_d;

    always_comb begin
        if (!ctl_i.valid) begin
            result_d = '0;
        end else if (ctl_i.is_word) begin
            result_d = {{(W-H){word_i[H-1]}}, word_i};
        end else begin
            result_d = dword_i;
        end
    end

    assign result_o = result_d;

endmodule

// File: rtl/rotate_unit.sv
module rotate_unit
    import rot_pkg::*;
(
    input  logic [XLEN-1:0]  operand_i,
    input  logic [IMM_W-1:0] shamt_imm_i,
    input  logic [XLEN-1:0]  shamt_reg_i,
    input  logic [2:0]       op_sel_i,
    output logic [XLEN-1:0]  result_o
);

    rot_ctl_t        ctl_d;
    logic [HLEN-1:0] word_rot_d;
    logic [XLEN-1:0] dword_rot_d;

    rot_amt_sel #(.W(XLEN)) u_sel (
        .op_i  (op_sel_i),
        .imm_i (shamt_imm_i),
        .reg_i (shamt_reg_i),
        .ctl_o (ctl_d)
    );

    rot_barrel #(.W(HLEN)) u_word_rot (
        .din_i  (operand_i[HLEN-1:0]),
        .amt_i  (ctl_d.amt[AMT_W-2:0]),
        .dout_o (word_rot_d)
    );

    rot_barrel #(.W(XLEN)) u_dword_rot (
        .din_i  (operand_i),
        .amt_i  (ctl_d.amt),
        .dout_o (dword_rot_d)
    );

    rot_result_fmt #(.W(XLEN)) u_fmt (
        .ctl_i    (ctl_d),
        .word_i   (word_rot_d),
        .dword_i  (dword_rot_d),
        .result_o (result_o)
    );

endmodule

// File: rtl/rotate_unit_chk.sv
module rotate_unit_chk
    import rot_pkg::*;
(
    input logic [XLEN-1:0]  operand_i,
    input logic [IMM_W-1:0] shamt_imm_i,
    input logic [XLEN-1:0]  shamt_reg_i,
    input logic [2:0]       op_sel_i,
    input logic [XLEN-1:0]  result_o
);

    logic unused_chk;
    assign unused_chk = ^shamt_reg_i;

    always_comb begin
        // R2: word results carry bit 31 into the upper half
        if (op_sel_i == 3'd0 || op_sel_i == 3'd1) begin
            a_r2_sign_ext: assert (result_o[XLEN-1:HLEN] == {HLEN{result_o[HLEN-1]}})
                else $error("R2 sign extension broken");
        end
        // R1: a word rotate keeps the bit population of the low word
        if (op_sel_i == 3'd0 || op_sel_i == 3'd1) begin
            a_r1_word_pop: assert ($countones(result_o[HLEN-1:0]) == $countones(operand_i[HLEN-1:0]))
                else $error("R1 word bit count changed");
        end
        // R6: a doubleword rotate keeps the bit population of the operand
        if (op_sel_i == 3'd2 || op_sel_i == 3'd3 || op_sel_i == 3'd4) begin
            a_r6_dword_pop: assert ($countones(result_o) == $countones(operand_i))
                else $error("R6 doubleword bit count changed");
        end
        // R7: zero immediate count on doubleword returns the operand
        if (op_sel_i == 3'd2 && shamt_imm_i == '0) begin
            a_r7_zero_identity: assert (result_o == operand_i)
                else $error("R7 zero count altered operand");
        end
        // R5: zero immediate with +32 swaps the halves
        if (op_sel_i == 3'd3 && shamt_imm_i == '0) begin
            a_r5_half_swap: assert (result_o == {operand_i[HLEN-1:0], operand_i[XLEN-1:HLEN]})
                else $error("R5 half swap wrong");
        end
        // R8: reserved codes yield zero
        if (op_sel_i > 3'd4) begin
            a_r8_reserved_zero: assert (result_o == '0)
                else $error("R8 reserved op not zero");
        end
    end

endmodule

bind rotate_unit rotate_unit_chk chk_i (.*);

// File: tb/rotate_unit_tb_top.sv
module rotate_unit_tb_top;

    logic        clk = 1'b0;
    logic [63:0] operand;
    logic [4:0]  imm;
    logic [63:0] rgv;
    logic [2:0]  op;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rotate_unit dut_i (
        .operand_i   (operand),
        .shamt_imm_i (imm),
        .shamt_reg_i (rgv),
        .op_sel_i    (op),
        .result_o    (result)
    );

    function automatic logic [63:0] model(int o, logic [4:0] im, logic [63:0] r, logic [63:0] x);
        logic [63:0] y = '0;
        int amt;
        int w;
        case (o)
            0: begin amt = int'(im);        w = 32; end
            1: begin amt = int'(r % 32);    w = 32; end
            2: begin amt = int'(im);        w = 64; end
            3: begin amt = int'(im) + 32;   w = 64; end
            4: begin amt = int'(r % 64);    w = 64; end
            default: return 64'd0;
        endcase
        for (int i = 0; i < w; i++) y[i] = x[(i + amt) % w];
        if (w == 32) for (int i = 32; i < 64; i++) y[i] = y[31];
        return y;
    endfunction

    task automatic compare(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h (op=%0d imm=%0d reg=%h opnd=%h)",
                     tag, act, exp, op, imm, rgv, operand);
        end
    endtask

    task automatic apply(string tag, int o, logic [4:0] im, logic [63:0] r, logic [63:0] x);
        @(posedge clk);
        op = 3'(o); imm = im; rgv = r; operand = x;
        @(negedge clk);
        compare(tag, result, model(o, im, r, x));
        if (o <= 1) compare("R2", result[63:32], {32{result[31]}});
    endtask

    function automatic string tag_of(int o);
        case (o)
            0: return "R1";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R9: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        op = 3'd7; imm = '0; rgv = '0; operand = 64'h0123_4567_89AB_CDEF;
        @(negedge clk);
        compare("R8", result, 64'd0);

        // R1: upper operand bits ignored
        apply("R1", 0, 5'd4, 64'd0, 64'hDEAD_BEEF_1234_5678);
        apply("R1", 0, 5'd4, 64'd0, 64'h0000_0000_1234_5678);
        apply("R1", 0, 5'd31, 64'd0, 64'hFFFF_FFFF_0000_0001);
        // R2: negative and positive word results
        apply("R2", 0, 5'd1, 64'd0, 64'h0000_0000_0000_0001);
        apply("R2", 0, 5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0002);
        // R3: high register bits ignored
        apply("R3", 1, 5'd0, 64'hFFFF_FFFF_FFFF_FFE1, 64'h0000_0000_8000_0003);
        apply("R3", 1, 5'd0, 64'h0000_0000_0000_0001, 64'h0000_0000_8000_0003);
        // R4, R5 boundaries
        apply("R4", 2, 5'd31, 64'd0, 64'h8000_0000_0000_0001);
        apply("R5", 3, 5'd31, 64'd0, 64'h8000_0000_0000_0001);
        apply("R5", 3, 5'd0, 64'd0, 64'h0123_4567_89AB_CDEF);
        // R6: high register bits ignored, count 63
        apply("R6", 4, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
        apply("R6", 4, 5'd0, 64'hAAAA_AAAA_AAAA_AAC1, 64'h0123_4567_89AB_CDEF);
        // R7: zero counts
        apply("R7", 0, 5'd0, 64'd0, 64'h1111_2222_9999_0000);
        apply("R7", 1, 5'd0, 64'hFFFF_FFFF_FFFF_FFE0, 64'h1111_2222_7999_0000);
        apply("R7", 2, 5'd0, 64'd0, 64'hFEDC_BA98_7654_3210);
        apply("R7", 4, 5'd0, 64'h0000_0000_0000_0040, 64'hFEDC_BA98_7654_3210);
        // R8: reserved codes
        for (int o = 5; o < 8; o++) apply("R8", o, 5'd7, 64'h3F, 64'hFFFF_FFFF_FFFF_FFFF);

        // R9: change between edges, result follows without a clock
        @(negedge clk);
        op = 3'd2; imm = 5'd8; rgv = '0; operand = 64'h00FF_0000_0000_0000;
        #3;
        compare("R9", result, model(2, 5'd8, 64'd0, 64'h00FF_0000_0000_0000));
        imm = 5'd16;
        #2;
        compare("R9", result, model(2, 5'd16, 64'd0, 64'h00FF_0000_0000_0000));

        for (int n = 0; n < 1500; n++) begin
            int o = $urandom_range(0, 7);
            logic [63:0] x = {$urandom, $urandom};
            logic [63:0] r = {$urandom, $urandom};
            logic [4:0]  im = 5'($urandom);
            apply(tag_of(o), o, im, r, x);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule